// File: doc/BRIEF.md
# Host Command Decoder with Circular Nibble Read Buffer

This block sits between a host processor and the switch and credit logic of an arcade I/O controller. The host talks to it through a 4-bit command port qualified by a one-cycle strobe. Small command codes change the operating mode, turn the switch-nibble remap on or off, or start the capture of a four-nibble coin/credit configuration. Any code with its top bit set returns one byte, built from the next two nibbles of an eight-slot circular buffer.

A fill process rewrites the buffer on every frame tick. The layout it writes depends on the current mode: raw switch nibbles in INIT, credit digits in IDLE, and the full play layout in ACTIVE. In ACTIVE the two DIP nibbles can pass through a fixed 16-entry substitution table. Credit arithmetic and coin handling are done elsewhere. Their results, and a start request, arrive as inputs.

Top module: `iocmd_nibble_buf`

## Requirements
- R1: A strobed command with bit 3 set, given while no configuration capture is pending, sets rd_valid high for exactly the next cycle. On that cycle rd_byte[3:0] holds buffer slot idx and rd_byte[7:4] holds slot idx+1. The index then advances by two. rd_byte keeps its value between reads.
- R2: The read index returns to 0 after slots 6 and 7 have been read, so the fifth read after a reset returns the same slots as the first.
- R3: Command 1 starts a capture. The next four strobed non-zero nibbles go into configuration slots 3, 2, 1 and 0, in that order. Zero nibbles are skipped. cfg_out holds slot i in bits 4i+3..4i. cfg_loading is high while the capture is pending. No read happens during the capture.
- R4: Command 2 selects IDLE and command 5 selects INIT. The mode output encodes IDLE=0, INIT=1, ACTIVE=2.
- R5: Command 3 turns the remap off and command 4 turns it on. Commands 0, 6 and 7 change neither mode, remap, configuration nor read index.
- R6: A frame tick in INIT loads slots 0..3 from sw_raw (slot i from bits 4i+3..4i) and loads slots 4..7 with 0xF.
- R7: A frame tick in IDLE loads slot 0 with credit_ones and slot 1 with credit_tens, and loads slots 2..7 with 0xF.
- R8: A frame tick in ACTIVE loads the slots as follows: 0 = credit_ones, 1 = credit_tens, 2 = DIP low, 3 = select_st, 4 = DIP high, 5 = shifter_st, 6 and 7 = 0xF.
- R9: When the remap is on, the ACTIVE DIP nibbles are replaced by table entry v, where the table for v = 0..15 reads F,E,D,5,C,9,7,6,B,3,A,4,1,2,0,8.
- R10: A frame tick with start_req high moves IDLE to ACTIVE. The start request has no effect in INIT or ACTIVE. A mode command in the same cycle takes precedence.
- R11: Reset selects INIT, zeroes all buffer slots, the read index and the configuration, turns the remap on, and clears rd_valid and rd_byte.
- R12: While a capture is pending, mode, remap and read codes are taken only as configuration data and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_data | input | 4 | Command nibble |
| frame_tick | input | 1 | One-cycle frame strobe, triggers buffer fill |
| start_req | input | 1 | Start request, sampled with frame_tick |
| sw_raw | input | 16 | Raw switch nibbles for INIT slots 0..3 |
| dip_lo | input | 4 | DIP switch low nibble |
| dip_hi | input | 4 | DIP switch high nibble |
| credit_ones | input | 4 | Credit BCD ones digit |
| credit_tens | input | 4 | Credit BCD tens digit |
| select_st | input | 4 | Select switch state nibble |
| shifter_st | input | 4 | Shifter switch state nibble |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_byte | output | 8 | Returned nibble pair |
| mode | output | 2 | Operating mode |
| remap_en | output | 1 | DIP remap enabled |
| cfg_loading | output | 1 | Configuration capture pending |
| cfg_out | output | 16 | Four configuration nibbles |

## Verification
The assertions assume that cmd_valid and frame_tick are single-cycle pulses sampled on the rising edge. They also assume that a start request only matters together with a frame tick. The bench drives each strobe for exactly one cycle, starting at a falling edge, and never raises start_req without frame_tick. The property that keeps the mode steady during a capture excludes cycles that carry a frame tick. The bench keeps frame ticks out of its capture sequences, so the start-to-ACTIVE path is never mixed with configuration data.

// File: rtl/ionb_pkg.sv
package ionb_pkg;
    localparam int NIB_W     = 4;
    localparam int SLOTS     = 8;
    localparam int CFG_SLOTS = 4;
    localparam int IDX_W     = $clog2(SLOTS);
    localparam int CNT_W     = $clog2(CFG_SLOTS + 1);

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_INIT   = 2'd1,
        MODE_ACTIVE = 2'd2
    } mode_e;

    typedef logic [SLOTS-1:0][NIB_W-1:0]     slots_t;
    typedef logic [CFG_SLOTS-1:0][NIB_W-1:0] cfg_t;

    localparam logic [NIB_W-1:0] NIB_ALL = '1;

    function automatic logic [3:0] dip_remap(input logic [3:0] v);
        logic [3:0] r;
        case (v)
            4'h0: r = 4'hF;  4'h1: r = 4'hE;  4'h2: r = 4'hD;  4'h3: r = 4'h5;
            4'h4: r = 4'hC;  4'h5: r = 4'h9;  4'h6: r = 4'h7;  4'h7: r = 4'h6;
            4'h8: r = 4'hB;  4'h9: r = 4'h3;  4'hA: r = 4'hA;  4'hB: r = 4'h4;
            4'hC: r = 4'h1;  4'hD: r = 4'h2;  4'hE: r = 4'h0;  default: r = 4'h8;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ionb_cmd_dec.sv
module ionb_cmd_dec
    import ionb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [NIB_W-1:0] cmd_data,
    input  logic             frame_tick,
    input  logic             start_req,
    output mode_e            mode_o,
    output logic             remap_o,
    output logic             loading_o,
    output cfg_t             cfg_o,
    output logic             rd_req_o
);
    typedef struct packed {
        mode_e            mode;
        logic             remap;
        logic [CNT_W-1:0] load_cnt;
        cfg_t             cfg;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_tick && start_req && st_q.mode == MODE_IDLE)
            st_d.mode = MODE_ACTIVE;
        if (cmd_valid) begin
            if (st_q.load_cnt != '0) begin
                if (cmd_data != '0) begin
                    for (int i = 0; i < CFG_SLOTS; i++)
                        if (st_q.load_cnt == CNT_W'(i + 1)) st_d.cfg[i] = cmd_data;
                    st_d.load_cnt = st_q.load_cnt - 1'b1;
                end
            end else begin
                case (cmd_data)
                    4'd1:    st_d.load_cnt = CNT_W'(CFG_SLOTS);
                    4'd2:    st_d.mode     = MODE_IDLE;
                    4'd3:    st_d.remap    = 1'b0;
                    4'd4:    st_d.remap    = 1'b1;
                    4'd5:    st_d.mode     = MODE_INIT;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode     <= MODE_INIT;
            st_q.remap    <= 1'b1;
            st_q.load_cnt <= '0;
            st_q.cfg      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign remap_o   = st_q.remap;
    assign loading_o = (st_q.load_cnt != '0);
    assign cfg_o     = st_q.cfg;
    assign rd_req_o  = cmd_valid && cmd_data[NIB_W-1] && (st_q.load_cnt == '0);
endmodule

// File: rtl/ionb_fill.sv
module ionb_fill
    import ionb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_tick,
    input  mode_e                    mode,
    input  logic                     remap,
    input  logic [4*NIB_W-1:0]       sw_raw,
    input  logic [NIB_W-1:0]         dip_lo,
    input  logic [NIB_W-1:0]         dip_hi,
    input  logic [NIB_W-1:0]         credit_ones,
    input  logic [NIB_W-1:0]         credit_tens,
    input  logic [NIB_W-1:0]         select_st,
    input  logic [NIB_W-1:0]         shifter_st,
    output slots_t                   slots_o
);
    typedef struct packed {
        slots_t slots;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic [NIB_W-1:0] lo_v, hi_v;

    always_comb begin
        lo_v = remap ? dip_remap(dip_lo) : dip_lo;
        hi_v = remap ? dip_remap(dip_hi) : dip_hi;
        st_d = st_q;
        if (frame_tick) begin
            for (int i = 0; i < SLOTS; i++) st_d.slots[i] = NIB_ALL;
            case (mode)
                MODE_INIT: begin
                    for (int i = 0; i < 4; i++)
                        st_d.slots[i] = sw_raw[i*NIB_W +: NIB_W];
                end
                MODE_IDLE: begin
                    st_d.slots[0] = credit_ones;
                    st_d.slots[1] = credit_tens;
                end
                MODE_ACTIVE: begin
                    st_d.slots[0] = credit_ones;
                    st_d.slots[1] = credit_tens;
                    st_d.slots[2] = lo_v;
                    st_d.slots[3] = select_st;
                    st_d.slots[4] = hi_v;
                    st_d.slots[5] = shifter_st;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slots_o = st_q.slots;
endmodule

// File: rtl/ionb_rd.sv
module ionb_rd
    import ionb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  slots_t             slots,
    output logic               rd_valid,
    output logic [2*NIB_W-1:0] rd_byte
);
    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic               vld;
        logic [2*NIB_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [IDX_W:0] idx_nxt;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        idx_nxt  = {1'b0, st_q.idx} + (IDX_W+1)'(2);
        if (rd_req) begin
            st_d.vld  = 1'b1;
            st_d.data = {slots[st_q.idx + IDX_W'(1)], slots[st_q.idx]};
            st_d.idx  = (idx_nxt >= (IDX_W+1)'(SLOTS)) ? '0 : idx_nxt[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.vld;
    assign rd_byte  = st_q.data;
endmodule

// File: rtl/iocmd_nibble_buf.sv
module iocmd_nibble_buf
    import ionb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_data,
    input  logic        frame_tick,
    input  logic        start_req,
    input  logic [15:0] sw_raw,
    input  logic [3:0]  dip_lo,
    input  logic [3:0]  dip_hi,
    input  logic [3:0]  credit_ones,
    input  logic [3:0]  credit_tens,
    input  logic [3:0]  select_st,
    input  logic [3:0]  shifter_st,
    output logic        rd_valid,
    output logic [7:0]  rd_byte,
    output logic [1:0]  mode,
    output logic        remap_en,
    output logic        cfg_loading,
    output logic [15:0] cfg_out
);
    mode_e  mode_w;
    cfg_t   cfg_w;
    slots_t slots_w;
    logic   rd_req_w;

    ionb_cmd_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .frame_tick(frame_tick),
        .start_req (start_req),
        .mode_o    (mode_w),
        .remap_o   (remap_en),
        .loading_o (cfg_loading),
        .cfg_o     (cfg_w),
        .rd_req_o  (rd_req_w)
    );

    ionb_fill u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .mode       (mode_w),
        .remap      (remap_en),
        .sw_raw     (sw_raw),
        .dip_lo     (dip_lo),
        .dip_hi     (dip_hi),
        .credit_ones(credit_ones),
        .credit_tens(credit_tens),
        .select_st  (select_st),
        .shifter_st (shifter_st),
        .slots_o    (slots_w)
    );

    ionb_rd u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req_w),
        .slots   (slots_w),
        .rd_valid(rd_valid),
        .rd_byte (rd_byte)
    );

    assign mode    = mode_w;
    assign cfg_out = cfg_w;
endmodule

// File: rtl/ionb_chk.sv
module ionb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [3:0]  cmd_data,
    input logic        frame_tick,
    input logic        rd_valid,
    input logic [1:0]  mode,
    input logic        remap_en,
    input logic        cfg_loading,
    input logic [15:0] cfg_out
);
    AST_READ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_data[3] && !cfg_loading)); // R1
    AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_loading && cmd_data == 4'd2) |=> (mode == 2'd0)); // R4
    AST_INIT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_loading && cmd_data == 4'd5) |=> (mode == 2'd1)); // R4
    AST_REMAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_loading && cmd_data == 4'd3) |=> !remap_en); // R5
    AST_REMAP_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cfg_loading && cmd_data == 4'd4) |=> remap_en); // R5
    AST_LOAD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cfg_loading && !frame_tick) |=> ($stable(mode) && $stable(remap_en))); // R12
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3); // R4
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(cfg_out)); // R3
endmodule

bind iocmd_nibble_buf ionb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .frame_tick (frame_tick),
    .rd_valid   (rd_valid),
    .mode       (mode),
    .remap_en   (remap_en),
    .cfg_loading(cfg_loading),
    .cfg_out    (cfg_out)
);

// File: tb/tb_iocmd_nibble_buf.sv
module tb_iocmd_nibble_buf;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 47;

    localparam logic [3:0] OP_CMD = 4'd0, OP_RD = 4'd1, OP_TICK = 4'd2, OP_TICKS = 4'd3,
                           OP_MODE = 4'd4, OP_CFG = 4'd5, OP_REMAP = 4'd6, OP_LOAD = 4'd7;

    // {req, op, data, expected}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd6,  OP_TICK,  4'h0, 16'h0000},  // R6 INIT fill
        {4'd6,  OP_RD,    4'h8, 16'h0021},  // R6
        {4'd1,  OP_RD,    4'hF, 16'h0043},  // R1
        {4'd6,  OP_RD,    4'h8, 16'h00FF},  // R6
        {4'd2,  OP_RD,    4'h9, 16'h00FF},  // R2
        {4'd2,  OP_RD,    4'hA, 16'h0021},  // R2 wrapped
        {4'd4,  OP_CMD,   4'h2, 16'h0000},  // R4
        {4'd4,  OP_MODE,  4'h0, 16'h0000},  // R4 IDLE
        {4'd7,  OP_TICK,  4'h0, 16'h0000},  // R7
        {4'd7,  OP_RD,    4'h8, 16'h00FF},  // R7
        {4'd7,  OP_RD,    4'h8, 16'h00FF},  // R7
        {4'd7,  OP_RD,    4'h8, 16'h00FF},  // R7
        {4'd7,  OP_RD,    4'h8, 16'h0027},  // R7
        {4'd10, OP_TICKS, 4'h0, 16'h0000},  // R10
        {4'd10, OP_MODE,  4'h0, 16'h0002},  // R10 ACTIVE
        {4'd8,  OP_TICK,  4'h0, 16'h0000},  // R8
        {4'd9,  OP_RD,    4'h8, 16'h0015},  // R9 remap 3->5
        {4'd9,  OP_RD,    4'h8, 16'h0027},  // R9 remap 6->7
        {4'd8,  OP_RD,    4'h8, 16'h00FF},  // R8
        {4'd8,  OP_RD,    4'h8, 16'h0027},  // R8
        {4'd5,  OP_CMD,   4'h3, 16'h0000},  // R5
        {4'd5,  OP_REMAP, 4'h0, 16'h0000},  // R5
        {4'd8,  OP_TICK,  4'h0, 16'h0000},  // R8
        {4'd5,  OP_RD,    4'h8, 16'h0013},  // R5 raw DIP
        {4'd5,  OP_RD,    4'h8, 16'h0026},  // R5 raw DIP
        {4'd5,  OP_CMD,   4'h6, 16'h0000},  // R5
        {4'd5,  OP_CMD,   4'h7, 16'h0000},  // R5
        {4'd5,  OP_CMD,   4'h0, 16'h0000},  // R5
        {4'd5,  OP_MODE,  4'h0, 16'h0002},  // R5
        {4'd5,  OP_REMAP, 4'h0, 16'h0000},  // R5
        {4'd5,  OP_RD,    4'h8, 16'h00FF},  // R5 index intact
        {4'd5,  OP_CMD,   4'h4, 16'h0000},  // R5
        {4'd5,  OP_REMAP, 4'h0, 16'h0001},  // R5
        {4'd3,  OP_CMD,   4'h1, 16'h0000},  // R3
        {4'd3,  OP_LOAD,  4'h0, 16'h0001},  // R3
        {4'd3,  OP_CMD,   4'h0, 16'h0000},  // R3 skipped
        {4'd12, OP_CMD,   4'h2, 16'h0000},  // R12 data, not IDLE
        {4'd12, OP_CMD,   4'h9, 16'h0000},  // R12 data, not read
        {4'd12, OP_CMD,   4'h5, 16'h0000},  // R12
        {4'd3,  OP_CMD,   4'hC, 16'h0000},  // R3
        {4'd3,  OP_CFG,   4'h0, 16'h295C},  // R3
        {4'd3,  OP_LOAD,  4'h0, 16'h0000},  // R3
        {4'd12, OP_MODE,  4'h0, 16'h0002},  // R12
        {4'd3,  OP_RD,    4'h8, 16'h0027},  // R3 no read consumed
        {4'd4,  OP_CMD,   4'h5, 16'h0000},  // R4
        {4'd10, OP_TICKS, 4'h0, 16'h0000},  // R10 ignored in INIT
        {4'd10, OP_MODE,  4'h0, 16'h0001}   // R10
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, frame_tick = 1'b0, start_req = 1'b0;
    logic [3:0] cmd_data = '0;
    logic [15:0] sw_raw = 16'h4321;
    logic [3:0] dip_lo = 4'h3, dip_hi = 4'h6, credit_ones = 4'h7, credit_tens = 4'h2;
    logic [3:0] select_st = 4'h1, shifter_st = 4'h2;
    logic        rd_valid, remap_en, cfg_loading;
    logic [7:0]  rd_byte;
    logic [1:0]  mode;
    logic [15:0] cfg_out;
    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    iocmd_nibble_buf dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [3:0] v);
        @(negedge clk); cmd_valid = 1'b1; cmd_data = v;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic send_tick(input logic s);
        @(negedge clk); frame_tick = 1'b1; start_req = s;
        @(negedge clk); frame_tick = 1'b0; start_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        check(11, "mode after reset", 16'(mode), 16'h1);
        check(11, "remap after reset", 16'(remap_en), 16'h1);
        check(11, "cfg after reset", cfg_out, 16'h0);
        check(11, "rd_valid after reset", 16'(rd_valid), 16'h0);
        check(11, "rd_byte after reset", 16'(rd_byte), 16'h0);
        check(11, "loading after reset", 16'(cfg_loading), 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] req, op, dat;
            logic [15:0] exp;
            {req, op, dat, exp} = VEC[i];
            case (op)
                OP_CMD:   send_cmd(dat);
                OP_TICK:  send_tick(1'b0);
                OP_TICKS: send_tick(1'b1);
                OP_RD: begin
                    send_cmd(dat);
                    check(int'(req), "read valid", 16'(rd_valid), 16'h1);
                    check(int'(req), "read byte", 16'(rd_byte), exp);
                end
                OP_MODE:  check(int'(req), "mode", 16'(mode), exp);
                OP_CFG:   check(int'(req), "cfg", cfg_out, exp);
                OP_REMAP: check(int'(req), "remap", 16'(remap_en), exp);
                default:  check(int'(req), "loading", 16'(cfg_loading), exp);
            endcase
        end

        // R1: rd_valid is a single-cycle pulse and rd_byte holds
        send_cmd(4'h8);
        @(negedge clk);
        check(1, "rd_valid pulse length", 16'(rd_valid), 16'h0);

        // R11: reset mid-run clears configuration, buffer and index
        do_reset();
        check(11, "cfg after second reset", cfg_out, 16'h0);
        check(11, "mode after second reset", 16'(mode), 16'h1);
        send_cmd(4'h8);
        check(11, "cleared buffer read", 16'(rd_byte), 16'h00);
        send_tick(1'b0);
        send_cmd(4'h8);
        check(11, "index restarted at 0", 16'(rd_byte), 16'h43);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule